// File: doc/BRIEF.md
# Nibble I/O Bus Register Addressing

This block is the I/O-side decoder of a small 4-bit controller. Each transfer carries a 4-bit module address and is marked as a read by an IN strobe or as a write by an OUT strobe. A plain transfer reaches the addressed module's primary register. To reach a module's auxiliary register, software first writes that module's address to a dedicated switching address. The switch is armed by that write and steers exactly one later transfer to the auxiliary register.

Registers wider than a nibble are moved by back-to-back transfers to the same address. An internal pointer picks the low nibble and then the high nibble. An extended module keeps a bank of subport registers. Its auxiliary register holds the subport number, and its primary accesses go to the subport that number selects. Three model modules carry storage: a plain nibble module, a byte-wide module and an extended module. Every other address is unpopulated.

Top module: `nibio_bus`

## Requirements
- R1: A transfer with io_out_stb high writes io_wdata into the selected register at the rising clock edge. While io_in_stb is high and io_out_stb is low, io_rdata shows the selected register combinationally, and a read changes no register. The nibble module is at address 1.
- R2: A write to switching address 4'hF with data A arms the switch for module A. The next transfer to address A then reaches that module's auxiliary register. Writing the value 4'hF to the switch disarms it.
- R3: The arm is one-shot. After one transfer (read or write) to the armed address, the arm is cleared, and later transfers to that address reach the primary register again.
- R4: While the switch is armed, a transfer to any other address goes to that address's primary register and leaves the arm unchanged.
- R5: The byte module at address 2 has an 8-bit primary register. Successive transfers to it alternate between the low nibble (bits 3:0), which comes first, and the high nibble (bits 7:4). Its auxiliary register is 4 bits wide.
- R6: The nibble pointer restarts at the low nibble whenever the previous transfer had a different address or a different register selection (primary or auxiliary). An idle cycle does not restart it.
- R7: The extended module at address 3 has an auxiliary register that holds a subport number (0 after reset). Its primary transfers read and write subport register [number] of a 16-entry bank.
- R8: Addresses 0 and 4 to 14 are unpopulated. Reads from them, and reads from the switching address, return 4'hF. Writes to them change no register.
- R9: A synchronous active-high reset clears every register to 0, disarms the switch and sets the nibble pointer to the low nibble.
- R10: io_rdata is 4'hF whenever io_in_stb is low or io_out_stb is high. When both strobes are high, the transfer is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Module address of the transfer |
| io_wdata | input | 4 | Write nibble |
| io_out_stb | input | 1 | Write strobe, one transfer per cycle |
| io_in_stb | input | 1 | Read strobe, one transfer per cycle |
| io_rdata | output | 4 | Read nibble, combinational |

## Verification
Some rules are checked by assertions on every cycle. The arm clears after a transfer to the armed address and holds across transfers elsewhere. The nibble pointer toggles on byte-primary transfers and returns low after any other transfer. Reads never modify storage, unpopulated writes are ignored, and io_rdata stays 4'hF when idle or unpopulated. Other behaviour can only be shown by the bench's directed scenarios, because it needs a whole sequence of transfers. These are: the data seen after an arm and write sequence, the nibble order of a byte register after an interleaved access, the routing of the subport bank through the stored number, and the arm being lost across a reset.

// File: rtl/nibio_pkg.sv
package nibio_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    localparam nib_t NIB_ONES = '1;

    // Where a transfer lands
    typedef enum logic [2:0] {
        RT_NONE,
        RT_SWITCH,
        RT_NIB_PRI,
        RT_NIB_AUX,
        RT_BYTE_PRI,
        RT_BYTE_AUX,
        RT_EXT_BANK,
        RT_EXT_SEL
    } route_e;

    // One bus transfer
    typedef struct packed {
        logic valid;
        logic write;
        nib_t addr;
        nib_t data;
    } xfer_t;

    // Identity of the register touched by a transfer
    typedef struct packed {
        logic used;
        nib_t addr;
        logic aux;
    } key_t;

    function automatic route_e pick_route(
        input nib_t a, input logic aux,
        input nib_t sw_a, input nib_t nib_a,
        input nib_t byte_a, input nib_t ext_a);
        route_e r;
        if (a == sw_a)        r = RT_SWITCH;
        else if (a == nib_a)  r = aux ? RT_NIB_AUX  : RT_NIB_PRI;
        else if (a == byte_a) r = aux ? RT_BYTE_AUX : RT_BYTE_PRI;
        else if (a == ext_a)  r = aux ? RT_EXT_SEL  : RT_EXT_BANK;
        else                  r = RT_NONE;
        return r;
    endfunction

endpackage

// File: rtl/nibio_switch.sv
module nibio_switch
    import nibio_pkg::*;
#(
    parameter nib_t SW_ADDR = 4'hF
) (
    input  logic  clk,
    input  logic  rst,
    input  xfer_t xf,
    output logic  aux_sel
);

    logic arm_vld_q;
    nib_t arm_addr_q;
    logic sw_write;

    assign sw_write = xf.valid && xf.write && (xf.addr == SW_ADDR);
    assign aux_sel  = arm_vld_q && (arm_addr_q == xf.addr) && (xf.addr != SW_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_vld_q  <= 1'b0;
            arm_addr_q <= '0;
        end else if (sw_write) begin
            arm_vld_q  <= (xf.data != SW_ADDR);
            arm_addr_q <= xf.data;
        end else if (xf.valid && aux_sel) begin
            arm_vld_q  <= 1'b0;
        end
    end

    p_arm_clear_r3: assert property (@(posedge clk) disable iff (rst)
        xf.valid && aux_sel |=> !arm_vld_q);

    p_arm_hold_r4: assert property (@(posedge clk) disable iff (rst)
        xf.valid && !aux_sel && (xf.addr != SW_ADDR)
        |=> $stable(arm_vld_q) && $stable(arm_addr_q));

    p_arm_reset_r9: assert property (@(posedge clk)
        rst |=> !arm_vld_q);

endmodule

// File: rtl/nibio_decode.sv
module nibio_decode
    import nibio_pkg::*;
#(
    parameter nib_t SW_ADDR   = 4'hF,
    parameter nib_t NIB_ADDR  = 4'h1,
    parameter nib_t BYTE_ADDR = 4'h2,
    parameter nib_t EXT_ADDR  = 4'h3
) (
    input  logic   clk,
    input  logic   rst,
    input  xfer_t  xf,
    input  logic   aux_sel,
    output route_e route,
    output logic   hi_sel
);

    key_t cur_key, last_key_q;
    logic ptr_q;
    logic same_reg;

    always_comb begin
        route    = pick_route(xf.addr, aux_sel, SW_ADDR, NIB_ADDR, BYTE_ADDR, EXT_ADDR);
        cur_key  = '{used: 1'b1, addr: xf.addr, aux: aux_sel};
        same_reg = (cur_key == last_key_q);
        hi_sel   = same_reg ? ptr_q : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_key_q <= '0;
            ptr_q      <= 1'b0;
        end else if (xf.valid) begin
            last_key_q <= cur_key;
            ptr_q      <= (route == RT_BYTE_PRI) ? ~hi_sel : 1'b0;
        end
    end

    p_ptr_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        xf.valid && (route == RT_BYTE_PRI) |=> ptr_q == !$past(hi_sel));

    p_ptr_restart_r6: assert property (@(posedge clk) disable iff (rst)
        xf.valid && (route != RT_BYTE_PRI) |=> !ptr_q);

endmodule

// File: rtl/nibio_models.sv
module nibio_models
    import nibio_pkg::*;
#(
    parameter int SUB_N = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  xfer_t  xf,
    input  route_e route,
    input  logic   hi_sel,
    output nib_t   rd
);

    localparam int SEL_W = $clog2(SUB_N);

    nib_t             nib_pri_q, nib_aux_q, byte_aux_q;
    logic [1:0][3:0]  byte_q;
    logic [SEL_W-1:0] sel_q;
    nib_t             bank_q [SUB_N];
    logic             we;

    assign we = xf.valid && xf.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            nib_pri_q  <= '0;
            nib_aux_q  <= '0;
            byte_aux_q <= '0;
            byte_q     <= '0;
            sel_q      <= '0;
        end else if (we) begin
            case (route)
                RT_NIB_PRI:  nib_pri_q      <= xf.data;
                RT_NIB_AUX:  nib_aux_q      <= xf.data;
                RT_BYTE_PRI: byte_q[hi_sel] <= xf.data;
                RT_BYTE_AUX: byte_aux_q     <= xf.data;
                RT_EXT_SEL:  sel_q          <= xf.data[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SUB_N; i++) begin
            if (rst)
                bank_q[i] <= '0;
            else if (we && (route == RT_EXT_BANK) && (sel_q == SEL_W'(i)))
                bank_q[i] <= xf.data;
        end
    end

    always_comb begin
        case (route)
            RT_NIB_PRI:  rd = nib_pri_q;
            RT_NIB_AUX:  rd = nib_aux_q;
            RT_BYTE_PRI: rd = byte_q[hi_sel];
            RT_BYTE_AUX: rd = byte_aux_q;
            RT_EXT_SEL:  rd = nib_t'(sel_q);
            RT_EXT_BANK: rd = bank_q[sel_q];
            default:     rd = NIB_ONES;
        endcase
    end

    p_read_pure_r1: assert property (@(posedge clk) disable iff (rst)
        xf.valid && !xf.write
        |=> $stable(nib_pri_q) && $stable(nib_aux_q) && $stable(byte_q)
            && $stable(byte_aux_q) && $stable(sel_q));

    p_ignored_write_r8: assert property (@(posedge clk) disable iff (rst)
        we && (route == RT_NONE || route == RT_SWITCH)
        |=> $stable(nib_pri_q) && $stable(nib_aux_q) && $stable(byte_q)
            && $stable(byte_aux_q) && $stable(sel_q));

endmodule

// File: rtl/nibio_bus.sv
module nibio_bus
    import nibio_pkg::*;
#(
    parameter nib_t SW_ADDR   = 4'hF,
    parameter nib_t NIB_ADDR  = 4'h1,
    parameter nib_t BYTE_ADDR = 4'h2,
    parameter nib_t EXT_ADDR  = 4'h3,
    parameter int   SUB_N     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] io_addr,
    input  logic [3:0] io_wdata,
    input  logic       io_out_stb,
    input  logic       io_in_stb,
    output logic [3:0] io_rdata
);

    xfer_t  xf;
    logic   aux_sel;
    logic   hi_sel;
    route_e route;
    nib_t   model_rd;

    always_comb begin
        xf.valid = io_out_stb || io_in_stb;
        xf.write = io_out_stb;
        xf.addr  = io_addr;
        xf.data  = io_wdata;
    end

    nibio_switch #(.SW_ADDR(SW_ADDR)) u_switch (
        .clk(clk), .rst(rst), .xf(xf), .aux_sel(aux_sel)
    );

    nibio_decode #(
        .SW_ADDR(SW_ADDR), .NIB_ADDR(NIB_ADDR),
        .BYTE_ADDR(BYTE_ADDR), .EXT_ADDR(EXT_ADDR)
    ) u_decode (
        .clk(clk), .rst(rst), .xf(xf), .aux_sel(aux_sel),
        .route(route), .hi_sel(hi_sel)
    );

    nibio_models #(.SUB_N(SUB_N)) u_models (
        .clk(clk), .rst(rst), .xf(xf), .route(route),
        .hi_sel(hi_sel), .rd(model_rd)
    );

    assign io_rdata = (io_in_stb && !io_out_stb) ? model_rd : NIB_ONES;

    p_unpop_read_r8: assert property (@(posedge clk) disable iff (rst)
        io_in_stb && (route == RT_NONE || route == RT_SWITCH) |-> io_rdata == 4'hF);

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        (!io_in_stb || io_out_stb) |-> io_rdata == 4'hF);

endmodule

// File: tb/tb_nibio_bus.sv
module tb_nibio_bus;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] io_addr = '0;
    logic [3:0] io_wdata = '0;
    logic       io_out_stb = 1'b0;
    logic       io_in_stb = 1'b0;
    logic [3:0] io_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    nibio_bus dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_out_stb(io_out_stb), .io_in_stb(io_in_stb), .io_rdata(io_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic o, input logic i, input logic [3:0] a,
                       input logic [3:0] d, output logic [3:0] seen);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_out_stb = o; io_in_stb = i;
        #1 seen = io_rdata;
        @(posedge clk);
        #1 io_out_stb = 1'b0; io_in_stb = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        logic [3:0] s;
        cyc(1'b1, 1'b0, a, d, s);
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] exp, input string req);
        logic [3:0] s;
        cyc(1'b0, 1'b1, a, 4'h0, s);
        check(req, s, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1 check("R10 idle", io_rdata, 4'hF);
        rd(4'h1, 4'h0, "R9 nib");
        rd(4'h2, 4'h0, "R9 byte");
        rd(4'h3, 4'h0, "R9 ext");
    endtask

    task automatic t_primary();
        wr(4'h1, 4'hA);
        rd(4'h1, 4'hA, "R1 write/read");
        rd(4'h1, 4'hA, "R1 read repeat");
    endtask

    task automatic t_aux();
        wr(4'hF, 4'h1); wr(4'h1, 4'h5);
        rd(4'h1, 4'hA, "R3 arm consumed");
        wr(4'hF, 4'h1);
        rd(4'h1, 4'h5, "R2 aux read");
        rd(4'h1, 4'hA, "R3 back to primary");
    endtask

    task automatic t_other();
        wr(4'hF, 4'h1);
        rd(4'h0, 4'hF, "R4 other addr");
        wr(4'h1, 4'h7);
        rd(4'h1, 4'hA, "R4 primary kept");
        wr(4'hF, 4'h1);
        rd(4'h1, 4'h7, "R4 arm held");
    endtask

    task automatic t_byte();
        wr(4'h2, 4'h3); wr(4'h2, 4'hC);
        rd(4'h2, 4'h3, "R5 low nibble");
        rd(4'h2, 4'hC, "R5 high nibble");
        wr(4'h2, 4'h5);
        rd(4'h1, 4'hA, "R6 interleave");
        wr(4'h2, 4'h6);
        rd(4'h2, 4'hC, "R6 restart then high");
        rd(4'h2, 4'h6, "R6 low rewritten");
        wr(4'hF, 4'h2); wr(4'h2, 4'h9);
        rd(4'h2, 4'h6, "R6 aux change restarts");
        wr(4'hF, 4'h2);
        rd(4'h2, 4'h9, "R5 byte aux");
    endtask

    task automatic t_ext();
        wr(4'h3, 4'h1);
        wr(4'hF, 4'h3); wr(4'h3, 4'h5);
        wr(4'h3, 4'hA);
        rd(4'h3, 4'hA, "R7 sub5");
        wr(4'hF, 4'h3); wr(4'h3, 4'h0);
        rd(4'h3, 4'h1, "R7 sub0");
        wr(4'hF, 4'h3);
        rd(4'h3, 4'h0, "R7 sel read");
        wr(4'hF, 4'h3); wr(4'h3, 4'hF);
        wr(4'h3, 4'hE);
        rd(4'h3, 4'hE, "R7 sub15");
        wr(4'hF, 4'h3); wr(4'h3, 4'h5);
        rd(4'h3, 4'hA, "R7 sub5 kept");
    endtask

    task automatic t_unpop();
        wr(4'h7, 4'h3);
        rd(4'h7, 4'hF, "R8 unpopulated read");
        rd(4'hE, 4'hF, "R8 addr 14");
        rd(4'hF, 4'hF, "R8 switch read");
        rd(4'h1, 4'hA, "R8 write ignored");
        wr(4'hF, 4'h1); wr(4'hF, 4'hF);
        rd(4'h1, 4'hA, "R2 disarm");
    endtask

    task automatic t_both();
        logic [3:0] s;
        cyc(1'b1, 1'b1, 4'h1, 4'h4, s);
        check("R10 both strobes rdata", s, 4'hF);
        rd(4'h1, 4'h4, "R10 both is write");
    endtask

    task automatic t_reset_arm();
        wr(4'hF, 4'h1);
        do_reset();
        wr(4'h1, 4'hB);
        rd(4'h1, 4'hB, "R3 reset clears arm");
        wr(4'hF, 4'h1);
        rd(4'h1, 4'h0, "R9 aux reset");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_primary();
        t_aux();
        t_other();
        t_byte();
        t_ext();
        t_unpop();
        t_both();
        t_reset_arm();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule